// File: doc/BRIEF.md
# DRAM Controller Interrupt and Error-Capture Registers

This block holds the interrupt and error-report state of a DRAM controller. Software reaches it through a simple register port with a 16-bit byte address, a write strobe and 16-bit write and read data. The controller core feeds it two kinds of event. The first is a pulse for each request that addresses memory outside the populated range, with that request's length and command type. The second is a level that rises when DRAM initialization is done. The block records these events in a four-bit status word. It keeps the length and type of the first offending request. Status bits are cleared by writing ones to an acknowledge field, and a mask selects which status bits drive the single interrupt output.

The block also holds the software start bit. Its value is the command-enable output that lets the controller core issue DRAM commands. Out-of-range events that arrive while the start bit is clear are dropped.

Top module: `dirq_regs`

## Requirements
- R1: After synchronous reset every register reads zero, and `irq` and `cmd_en` are low.
- R2: Registers sit at byte addresses 0x8000, 0x8008, 0x8010 and 0x8018. The register at 0x8000, every other address, and every bit not named below read as zero.
- R3: An out-of-range pulse accepted while status bit 0 is clear sets status bit 0 (at 0x8008 bits 3:0). In the same edge it captures the length into 0x8010 bits 15:8 and the type into 0x8018 bits 2:0.
- R4: An out-of-range pulse accepted while status bit 0 is set sets status bit 1 and leaves the captured length and type unchanged.
- R5: A rising edge of `init_done` sets status bit 2. A level held high does not set it again after it has been acknowledged.
- R6: Status bit 3 always reads as the OR of status bits 2:0.
- R7: Writing 0x8008 with a one in bit 8, 9 or 10 clears status bit 0, 1 or 2 respectively. A zero in those bits leaves the status bit as it was, and bits 10:8 read back as zero.
- R8: When an event sets a status bit in the same cycle that an acknowledge clears that bit, the bit ends up set.
- R9: `irq` is a register. In each cycle it equals the OR, over all four status bits, of status AND mask, where the status and mask are the values from the previous cycle. Mask sits at 0x8010 bits 3:0, and a one enables a status bit.
- R10: The start bit at 0x8018 bit 8 is readable and writable, and `cmd_en` equals it from the cycle after the write.
- R11: Out-of-range pulses that arrive while the start bit is clear change no status bit and no captured field.
- R12: Writes to the status, length and type fields leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register byte address (read and write) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| oor_evt | input | 1 | One-cycle pulse: out-of-range request seen |
| oor_len | input | 8 | Length of that request |
| oor_type | input | 3 | Command type of that request |
| init_done | input | 1 | Level from the core: DRAM initialization finished |
| irq | output | 1 | Masked interrupt, registered |
| cmd_en | output | 1 | Start bit: DRAM command issue allowed |

## Verification
The bench drives an acknowledge in the same cycle as an event for the same bit. A design that gives the clear priority would lose the event, and status would read clear. It sends back-to-back out-of-range pulses. A design that re-captures on every event would show the second request's length and type instead of the first. It holds `init_done` high across an acknowledge, where a level-sensitive design would set bit 2 again at once. It also pulses events before the start bit is written, where a design that does not gate them would report a fault that software never enabled.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int REG_DATA_W = 16;
    localparam int NUM_REGS   = 4;
    localparam int REG_STRIDE = 8;
    localparam int NUM_SRC    = 3;
    localparam int STAT_W     = NUM_SRC + 1;

    localparam int ACK_LSB    = 8;
    localparam int LEN_LSB    = 8;
    localparam int START_BIT  = 8;

    typedef enum logic [1:0] {
        RIDX_RSVD = 2'd0,
        RIDX_STAT = 2'd1,
        RIDX_MASK = 2'd2,
        RIDX_CTRL = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic any;
        logic init_done;
        logic multi;
        logic single;
    } stat_t;

    typedef struct packed {
        logic ack;
        logic mask;
        logic ctrl;
    } wr_strobe_t;

    function automatic stat_t make_status(input logic [NUM_SRC-1:0] raw);
        stat_t s;
        s.any       = |raw;
        s.init_done = raw[2];
        s.multi     = raw[1];
        s.single    = raw[0];
        return s;
    endfunction

endpackage

// File: rtl/dirq_decode.sv
module dirq_decode
    import dirq_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h8000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    output logic [NUM_REGS-1:0] hit,
    output wr_strobe_t          we
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(BASE) + ADDR_W'(i * REG_STRIDE);
        assign hit[i] = (addr == REG_ADDR);
    end

    always_comb begin
        we.ack  = wr & hit[RIDX_STAT];
        we.mask = wr & hit[RIDX_MASK];
        we.ctrl = wr & hit[RIDX_CTRL];
    end

endmodule

// File: rtl/dirq_status.sv
module dirq_status
    import dirq_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int TYPE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               oor_evt,
    input  logic [LEN_W-1:0]   oor_len,
    input  logic [TYPE_W-1:0]  oor_type,
    input  logic               init_done,
    input  logic               ack_we,
    input  logic [NUM_SRC-1:0] ack_bits,
    output stat_t              status,
    output logic [LEN_W-1:0]   cap_len,
    output logic [TYPE_W-1:0]  cap_type
);

    logic [NUM_SRC-1:0] raw_q, raw_d, set_v, clr_v;
    logic               init_prev_q;
    logic               evt_ok, first_evt, again_evt, init_rise;
    logic [LEN_W-1:0]   len_q;
    logic [TYPE_W-1:0]  type_q;

    always_comb begin
        evt_ok    = oor_evt & enable;
        first_evt = evt_ok & ~raw_q[0];
        again_evt = evt_ok & raw_q[0];
        init_rise = init_done & ~init_prev_q;
        set_v     = {init_rise, again_evt, first_evt};
        clr_v     = ack_we ? ack_bits : '0;
    end

    // set has priority over clear on every bit
    for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
        assign raw_d[b] = set_v[b] | (raw_q[b] & ~clr_v[b]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q       <= '0;
            init_prev_q <= 1'b0;
            len_q       <= '0;
            type_q      <= '0;
        end else begin
            raw_q       <= raw_d;
            init_prev_q <= init_done;
            if (first_evt) begin
                len_q  <= oor_len;
                type_q <= oor_type;
            end
        end
    end

    assign status   = make_status(raw_q);
    assign cap_len  = len_q;
    assign cap_type = type_q;

endmodule

// File: rtl/dirq_ctl.sv
module dirq_ctl
    import dirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              ctrl_we,
    input  logic              start_wdata,
    input  stat_t             status,
    output logic [STAT_W-1:0] mask,
    output logic              start,
    output logic              irq
);

    logic [STAT_W-1:0] mask_q;
    logic              start_q, irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            start_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (mask_we) mask_q  <= mask_wdata;
            if (ctrl_we) start_q <= start_wdata;
            irq_q <= |(STAT_W'(status) & mask_q);
        end
    end

    assign mask  = mask_q;
    assign start = start_q;
    assign irq   = irq_q;

endmodule

// File: rtl/dirq_regs.sv
module dirq_regs
    import dirq_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h8000,
    parameter int          LEN_W  = 8,
    parameter int          TYPE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic                  oor_evt,
    input  logic [LEN_W-1:0]      oor_len,
    input  logic [TYPE_W-1:0]     oor_type,
    input  logic                  init_done,
    output logic                  irq,
    output logic                  cmd_en
);

    logic [NUM_REGS-1:0] hit;
    wr_strobe_t          we;
    stat_t               status;
    logic [STAT_W-1:0]   mask;
    logic                start;
    logic [LEN_W-1:0]    cap_len;
    logic [TYPE_W-1:0]   cap_type;

    dirq_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr (reg_addr),
        .wr   (reg_wr),
        .hit  (hit),
        .we   (we)
    );

    dirq_status #(.LEN_W(LEN_W), .TYPE_W(TYPE_W)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .enable    (start),
        .oor_evt   (oor_evt),
        .oor_len   (oor_len),
        .oor_type  (oor_type),
        .init_done (init_done),
        .ack_we    (we.ack),
        .ack_bits  (reg_wdata[ACK_LSB +: NUM_SRC]),
        .status    (status),
        .cap_len   (cap_len),
        .cap_type  (cap_type)
    );

    dirq_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .mask_we     (we.mask),
        .mask_wdata  (reg_wdata[STAT_W-1:0]),
        .ctrl_we     (we.ctrl),
        .start_wdata (reg_wdata[START_BIT]),
        .status      (status),
        .mask        (mask),
        .start       (start),
        .irq         (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (1'b1)
            hit[RIDX_RSVD]: reg_rdata = '0;
            hit[RIDX_STAT]: reg_rdata[STAT_W-1:0] = status;
            hit[RIDX_MASK]: begin
                reg_rdata[STAT_W-1:0]       = mask;
                reg_rdata[LEN_LSB +: LEN_W] = cap_len;
            end
            hit[RIDX_CTRL]: begin
                reg_rdata[TYPE_W-1:0] = cap_type;
                reg_rdata[START_BIT]  = start;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign cmd_en = start;

endmodule

// File: rtl/dirq_checker.sv
module dirq_checker
    import dirq_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h8000,
    parameter int          LEN_W  = 8,
    parameter int          TYPE_W = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  reg_wr,
    input logic [REG_DATA_W-1:0] reg_wdata,
    input logic                  oor_evt,
    input logic [LEN_W-1:0]      oor_len,
    input logic [TYPE_W-1:0]     oor_type,
    input logic [STAT_W-1:0]     status,
    input logic [STAT_W-1:0]     mask,
    input logic [LEN_W-1:0]      cap_len,
    input logic [TYPE_W-1:0]     cap_type,
    input logic                  irq,
    input logic                  cmd_en
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE) + ADDR_W'(1 * REG_STRIDE);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE) + ADDR_W'(3 * REG_STRIDE);

    logic first_ok;
    assign first_ok = oor_evt & cmd_en & ~status[0];

    AST_FIRST_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        first_ok |=> (status[0] && cap_len == $past(oor_len) && cap_type == $past(oor_type))); // R3

    AST_REPEAT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (oor_evt && cmd_en && status[0]) |=> (status[1] && $stable(cap_len) && $stable(cap_type))); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_STAT && reg_wdata[ACK_LSB] && !first_ok) |=> !status[0]); // R7

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == |($past(status) & $past(mask)))); // R9

    AST_START_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL) |=> (cmd_en == $past(reg_wdata[START_BIT]))); // R10

    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (oor_evt && !cmd_en && !status[0]) |=> (!status[0] && $stable(cap_len))); // R11

endmodule

bind dirq_regs dirq_checker #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .LEN_W  (LEN_W),
    .TYPE_W (TYPE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .oor_evt   (oor_evt),
    .oor_len   (oor_len),
    .oor_type  (oor_type),
    .status    (status),
    .mask      (mask),
    .cap_len   (cap_len),
    .cap_type  (cap_type),
    .irq       (irq),
    .cmd_en    (cmd_en)
);

// File: tb/dirq_regs_tb.sv
`timescale 1ns/100ps
module dirq_regs_tb;

    localparam logic [15:0] A0 = 16'h8000;
    localparam logic [15:0] A1 = 16'h8008;
    localparam logic [15:0] A2 = 16'h8010;
    localparam logic [15:0] A3 = 16'h8018;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] reg_addr = A0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        oor_evt = 1'b0;
    logic [7:0]  oor_len = '0;
    logic [2:0]  oor_type = '0;
    logic        init_done = 1'b0;
    logic        irq, cmd_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic init_lvl = 1'b0;

    logic [2:0] m_raw = '0;
    logic [7:0] m_len = '0;
    logic [2:0] m_type = '0;
    logic [3:0] m_mask = '0;
    logic       m_start = 1'b0;
    logic       m_irq = 1'b0;
    logic       m_iprev = 1'b0;

    always #2.5 clk = ~clk;

    dirq_regs u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .oor_evt(oor_evt),
        .oor_len(oor_len), .oor_type(oor_type), .init_done(init_done),
        .irq(irq), .cmd_en(cmd_en)
    );

    function automatic logic [15:0] exp_rd(input logic [15:0] a);
        case (a)
            A1:      return {12'h000, |m_raw, m_raw};
            A2:      return {m_len, 4'h0, m_mask};
            A3:      return {7'h00, m_start, 5'h00, m_type};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic ev, input logic [7:0] ln, input logic [2:0] ty,
                        input logic wr, input logic [15:0] ad, input logic [15:0] wd,
                        input logic [15:0] rad, input string tag);
        logic [2:0] nraw, clr;
        logic       nirq;
        @(negedge clk);
        oor_evt = ev; oor_len = ln; oor_type = ty;
        reg_wr = wr; reg_addr = ad; reg_wdata = wd; init_done = init_lvl;
        nirq = |({|m_raw, m_raw} & m_mask);
        clr  = (wr && ad == A1) ? wd[10:8] : 3'b000;
        nraw = m_raw & ~clr;
        if (ev && m_start) begin
            if (!m_raw[0]) begin
                nraw[0] = 1'b1; m_len = ln; m_type = ty;
            end else begin
                nraw[1] = 1'b1;
            end
        end
        if (init_lvl && !m_iprev) nraw[2] = 1'b1;
        m_iprev = init_lvl;
        if (wr && ad == A2) m_mask = wd[3:0];
        if (wr && ad == A3) m_start = wd[8];
        m_raw = nraw;
        m_irq = nirq;
        @(posedge clk); #1;
        oor_evt = 1'b0; reg_wr = 1'b0; reg_addr = rad; #1;
        chk(tag, reg_rdata, exp_rd(rad));
        chk("R9", {15'h0, irq}, {15'h0, m_irq});
        chk("R10", {15'h0, cmd_en}, {15'h0, m_start});
    endtask

    task automatic idle_read(input logic [15:0] rad, input string tag);
        step(1'b0, 8'h00, 3'h0, 1'b0, A0, 16'h0000, rad, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] addrs [6];
        addrs = '{A0, A1, A2, A3, 16'h8004, 16'h8020};
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1: reset state
        chk("R1", {15'h0, irq}, 16'h0);
        chk("R1", {15'h0, cmd_en}, 16'h0);
        foreach (addrs[i]) begin
            reg_addr = addrs[i]; #0.2;
            chk("R1", reg_rdata, 16'h0000);
        end
        // R11: event before start is dropped
        step(1'b1, 8'hA7, 3'h6, 1'b0, A0, 16'h0000, A1, "R11");
        idle_read(A2, "R11");
        // R10: start bit set; R12: type field not writable
        step(1'b0, 8'h00, 3'h0, 1'b1, A3, 16'h01FF, A3, "R12");
        // R12: status bits 3:0 not writable
        step(1'b0, 8'h00, 3'h0, 1'b1, A1, 16'h000F, A1, "R12");
        // R12: length not writable, mask written
        step(1'b0, 8'h00, 3'h0, 1'b1, A2, 16'hFF0F, A2, "R12");
        // R2: reserved register and unmapped address
        step(1'b0, 8'h00, 3'h0, 1'b1, A0, 16'hFFFF, A0, "R2");
        step(1'b0, 8'h00, 3'h0, 1'b1, 16'h8004, 16'hFFFF, 16'h8004, "R2");
        // R3: first event captures
        step(1'b1, 8'h5A, 3'h5, 1'b0, A0, 16'h0000, A2, "R3");
        idle_read(A3, "R3");
        // R4: repeat event keeps capture
        step(1'b1, 8'h33, 3'h2, 1'b0, A0, 16'h0000, A1, "R4");
        idle_read(A2, "R4");
        idle_read(A3, "R4");
        // R7: acknowledge bit 0 only, ack field reads zero
        step(1'b0, 8'h00, 3'h0, 1'b1, A1, 16'h0100, A1, "R7");
        step(1'b0, 8'h00, 3'h0, 1'b1, A1, 16'h0700, A1, "R7");
        // R8: set beats clear, bit 0 then bit 1
        step(1'b1, 8'h11, 3'h1, 1'b1, A1, 16'h0100, A1, "R8");
        step(1'b1, 8'h22, 3'h3, 1'b1, A1, 16'h0200, A1, "R8");
        // R5: init edge sets bit 2; held level does not set again
        init_lvl = 1'b1;
        idle_read(A1, "R5");
        step(1'b0, 8'h00, 3'h0, 1'b1, A1, 16'h0400, A1, "R5");
        idle_read(A1, "R5");
        // R6: clear all, summary bit follows
        step(1'b0, 8'h00, 3'h0, 1'b1, A1, 16'h0300, A1, "R6");
        // R9: mask off with status set
        step(1'b1, 8'h44, 3'h4, 1'b1, A2, 16'h0000, A1, "R9");
        idle_read(A1, "R9");
        step(1'b0, 8'h00, 3'h0, 1'b1, A2, 16'h0002, A2, "R9");
        idle_read(A1, "R9");
        // random phase
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic        ev, wr;
            logic [15:0] ad, wd, rad;
            ev  = ($urandom % 4) == 0;
            wr  = ($urandom % 3) == 0;
            ad  = addrs[$urandom % 6];
            wd  = 16'($urandom);
            if (ad == A3 && ($urandom % 4) != 0) wd[8] = 1'b1;
            rad = addrs[$urandom % 6];
            if (($urandom % 16) == 0) init_lvl = ~init_lvl;
            step(ev, 8'($urandom), 3'($urandom), wr, ad, wd, rad, "R6");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule